// File: doc/BRIEF.md
# Banked Effective Address Generator

This block computes the 24-bit address of a single operand access for a processor that pairs an 8-bit bank byte with a 16-bit in-bank offset. Each cycle it takes an addressing-mode code together with everything that mode may need. That covers the operand bytes (an 8-bit direct offset, a 16-bit absolute value and a 24-bit long value), a 24-bit pointer already fetched from memory, the X, Y and stack registers, the index-width select, the direct-page base and the data and program bank registers. One clock later it presents the bank byte, the offset and a flag that asks the sequencer for one extra cycle.

Direct-page and stack-relative accesses always land in bank 0 and wrap inside it. Absolute accesses take the data bank, and code accesses take the program bank; in both, the offset wraps without touching the bank byte. Long and pointer-based accesses carry across the whole 24 bits. Fetching the pointer, sequencing the instruction and running the memory bus are done elsewhere.

Top module: `eag_top`

## Requirements
- R1: While rst_n is low, bank_o, ofs_o and extra_cyc_o are all zero. This holds right after reset and when reset is asserted in the middle of a run.
- R2: Mode 0 (direct) gives bank 0x00 and offset (dpage_i + dp_ofs_i) mod 2^16.
- R3: Mode 1 (direct,X) and mode 2 (direct,Y) give bank 0x00 and offset (dpage_i + dp_ofs_i + index) mod 2^16. The sum never carries into the bank.
- R4: Mode 3 (absolute), mode 4 (absolute,X) and mode 5 (absolute,Y) give bank dbank_i and offset (abs_i + index) mod 2^16. The bank is never incremented.
- R5: Mode 6 (long) gives bank long_i[23:16] and offset long_i[15:0], unchanged.
- R6: Mode 7 (long,X) gives the 24-bit result (long_i + X) mod 2^24, so a carry out of the offset does increment the bank.
- R7: Mode 8 (stack-relative) gives bank 0x00 and offset (sp_i + dp_ofs_i) mod 2^16.
- R8: Mode 9 (pointer long) gives ptr_i unchanged as the address. Mode 10 (pointer long,Y) gives (ptr_i + Y) mod 2^24.
- R9: Mode 11 (code) gives bank pbank_i and offset abs_i.
- R10: When idx_narrow_i is 1, only bits [7:0] of X or Y enter any sum; the upper byte is ignored. When it is 0, all 16 bits enter the sum.
- R11: extra_cyc_o is 1 exactly when the mode is 0, 1, 2, 9 or 10 and dpage_i[7:0] is not zero. For every other mode it is 0.
- R12: Mode codes 12 to 15 give bank 0x00, offset 0x0000 and extra_cyc_o equal to 0.
- R13: The outputs are registered. A change on the inputs shows up only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | Addressing-mode code (0 to 11 defined) |
| idx_narrow_i | input | 1 | 1: index registers are 8 bits wide |
| dp_ofs_i | input | 8 | Direct or stack-relative operand byte |
| abs_i | input | 16 | Absolute operand |
| long_i | input | 24 | Long operand |
| ptr_i | input | 24 | Pointer fetched from the direct page |
| x_i | input | 16 | X index register |
| y_i | input | 16 | Y index register |
| sp_i | input | 16 | Stack pointer |
| dpage_i | input | 16 | Direct-page base |
| dbank_i | input | 8 | Data bank register |
| pbank_i | input | 8 | Program bank register |
| bank_o | output | 8 | Effective bank byte |
| ofs_o | output | 16 | Effective in-bank offset |
| extra_cyc_o | output | 1 | Request for one extra cycle |

## Verification
The bench builds the block with its default widths: an 8-bit bank, a 16-bit offset and an 8-bit direct operand. With these widths, every wrap point sits at the real 0xFFFF and 0xFFFFFF boundaries. Single vectors can therefore show a bank-0 sum folding back to a low offset, an absolute sum wrapping while the data bank stays put, and a long sum carrying into the bank byte or wrapping past 0xFFFFFF. An 8-bit index select also brings within reach the case where a non-zero upper index byte is discarded.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [3:0] {
    AM_DIR        = 4'd0,
    AM_DIR_X      = 4'd1,
    AM_DIR_Y      = 4'd2,
    AM_ABS        = 4'd3,
    AM_ABS_X      = 4'd4,
    AM_ABS_Y      = 4'd5,
    AM_LONG       = 4'd6,
    AM_LONG_X     = 4'd7,
    AM_STK        = 4'd8,
    AM_IND_LONG   = 4'd9,
    AM_IND_LONG_Y = 4'd10,
    AM_CODE       = 4'd11
  } mode_e;

  // Modes whose timing depends on direct-page alignment
  function automatic logic uses_dpage(input logic [3:0] m);
    return (m == AM_DIR) || (m == AM_DIR_X) || (m == AM_DIR_Y) ||
           (m == AM_IND_LONG) || (m == AM_IND_LONG_Y);
  endfunction
endpackage

// File: rtl/eag_idx_trim.sv
// Narrows the index registers to their low part when the narrow select is set.
module eag_idx_trim #(
  parameter int OFS_W    = 16,
  parameter int NARROW_W = 8,
  parameter int N_IDX    = 2
) (
  input  logic                         narrow_i,
  input  logic [N_IDX-1:0][OFS_W-1:0]  idx_i,
  output logic [N_IDX-1:0][OFS_W-1:0]  idx_o
);
  localparam int HI_W = OFS_W - NARROW_W;

  for (genvar g = 0; g < N_IDX; g++) begin : g_trim
    assign idx_o[g] = narrow_i ? {{HI_W{1'b0}}, idx_i[g][NARROW_W-1:0]} : idx_i[g];
  end
endmodule

// File: rtl/eag_bank_add.sv
// In-bank adder: result wraps modulo 2^OFS_W, never carries into the bank.
module eag_bank_add #(
  parameter int OFS_W = 16,
  parameter int DP_W  = 8
) (
  input  logic [OFS_W-1:0] base_i,
  input  logic [DP_W-1:0]  disp_i,
  input  logic [OFS_W-1:0] idx_i,
  output logic [OFS_W-1:0] sum_o
);
  function automatic logic [OFS_W-1:0] wrap_add(input logic [OFS_W-1:0] b,
                                                 input logic [DP_W-1:0]  d,
                                                 input logic [OFS_W-1:0] i);
    return b + OFS_W'(d) + i;
  endfunction

  assign sum_o = wrap_add(base_i, disp_i, idx_i);
endmodule

// File: rtl/eag_long_add.sv
// Linear adder across the full bank:offset space, wrapping modulo 2^ADDR_W.
module eag_long_add #(
  parameter int ADDR_W = 24,
  parameter int OFS_W  = 16
) (
  input  logic [ADDR_W-1:0] lin_i,
  input  logic [OFS_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] sum_o
);
  function automatic logic [ADDR_W-1:0] lin_add(input logic [ADDR_W-1:0] a,
                                                input logic [OFS_W-1:0]  i);
    return a + ADDR_W'(i);
  endfunction

  assign sum_o = lin_add(lin_i, idx_i);
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int OFS_W  = 16,
  parameter int DP_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        mode_i,
  input  logic              idx_narrow_i,
  input  logic [DP_W-1:0]   dp_ofs_i,
  input  logic [OFS_W-1:0]  abs_i,
  input  logic [BANK_W+OFS_W-1:0] long_i,
  input  logic [BANK_W+OFS_W-1:0] ptr_i,
  input  logic [OFS_W-1:0]  x_i,
  input  logic [OFS_W-1:0]  y_i,
  input  logic [OFS_W-1:0]  sp_i,
  input  logic [OFS_W-1:0]  dpage_i,
  input  logic [BANK_W-1:0] dbank_i,
  input  logic [BANK_W-1:0] pbank_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [OFS_W-1:0]  ofs_o,
  output logic              extra_cyc_o
);
  localparam int ADDR_W = BANK_W + OFS_W;

  mode_e m;
  assign m = mode_e'(mode_i);

  // ---- index trimming ----
  logic [1:0][OFS_W-1:0] idx_raw, idx_eff;
  logic [OFS_W-1:0]      xe, ye;
  assign idx_raw = {y_i, x_i};

  eag_idx_trim #(.OFS_W(OFS_W), .NARROW_W(DP_W), .N_IDX(2)) u_trim (
    .narrow_i (idx_narrow_i),
    .idx_i    (idx_raw),
    .idx_o    (idx_eff)
  );
  assign xe = idx_eff[0];
  assign ye = idx_eff[1];

  // ---- index selection per adder ----
  logic [OFS_W-1:0] dp_idx, abs_idx;
  always_comb begin
    dp_idx  = '0;
    abs_idx = '0;
    if (m == AM_DIR_X) dp_idx  = xe;
    if (m == AM_DIR_Y) dp_idx  = ye;
    if (m == AM_ABS_X) abs_idx = xe;
    if (m == AM_ABS_Y) abs_idx = ye;
  end

  // ---- in-bank sums ----
  logic [OFS_W-1:0] dp_sum, stk_sum, abs_sum;

  eag_bank_add #(.OFS_W(OFS_W), .DP_W(DP_W)) u_dp_add (
    .base_i (dpage_i), .disp_i (dp_ofs_i), .idx_i (dp_idx), .sum_o (dp_sum)
  );
  eag_bank_add #(.OFS_W(OFS_W), .DP_W(DP_W)) u_stk_add (
    .base_i (sp_i), .disp_i (dp_ofs_i), .idx_i ('0), .sum_o (stk_sum)
  );
  eag_bank_add #(.OFS_W(OFS_W), .DP_W(DP_W)) u_abs_add (
    .base_i (abs_i), .disp_i ('0), .idx_i (abs_idx), .sum_o (abs_sum)
  );

  // ---- full-width sums ----
  logic [ADDR_W-1:0] long_x_sum, ptr_y_sum;

  eag_long_add #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_long_add (
    .lin_i (long_i), .idx_i (xe), .sum_o (long_x_sum)
  );
  eag_long_add #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ptr_add (
    .lin_i (ptr_i), .idx_i (ye), .sum_o (ptr_y_sum)
  );

  // ---- result selection ----
  logic [BANK_W-1:0] nxt_bank;
  logic [OFS_W-1:0]  nxt_ofs;
  always_comb begin
    nxt_bank = '0;
    nxt_ofs  = '0;
    case (m)
      AM_DIR, AM_DIR_X, AM_DIR_Y: nxt_ofs = dp_sum;
      AM_STK:                     nxt_ofs = stk_sum;
      AM_ABS, AM_ABS_X, AM_ABS_Y: begin nxt_bank = dbank_i; nxt_ofs = abs_sum; end
      AM_LONG:                    {nxt_bank, nxt_ofs} = long_i;
      AM_LONG_X:                  {nxt_bank, nxt_ofs} = long_x_sum;
      AM_IND_LONG:                {nxt_bank, nxt_ofs} = ptr_i;
      AM_IND_LONG_Y:              {nxt_bank, nxt_ofs} = ptr_y_sum;
      AM_CODE:                    begin nxt_bank = pbank_i; nxt_ofs = abs_i; end
      default:                    ;
    endcase
  end

  // ---- penalty events, named for the assertions ----
  logic dp_mode_w, dp_misaligned_w, nxt_pen;
  assign dp_mode_w       = uses_dpage(mode_i);
  assign dp_misaligned_w = |dpage_i[DP_W-1:0];
  assign nxt_pen         = dp_mode_w & dp_misaligned_w;

  // ---- output register ----
  logic warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_o      <= '0;
      ofs_o       <= '0;
      extra_cyc_o <= 1'b0;
      warm_q      <= 1'b0;
    end else begin
      bank_o      <= nxt_bank;
      ofs_o       <= nxt_ofs;
      extra_cyc_o <= nxt_pen;
      warm_q      <= 1'b1;
    end
  end

  // ---- assertions ----
  // R2 / R3 / R7: bank-0 modes never leave bank 0
  a_r2_dp_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q && ($past(mode_i) <= 4'(AM_DIR_Y) || $past(mode_i) == 4'(AM_STK)))
      |-> bank_o == '0);

  // R4: absolute modes keep the data bank whatever the offset sum does
  a_r4_abs_keeps_dbank: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q && $past(mode_i) >= 4'(AM_ABS) && $past(mode_i) <= 4'(AM_ABS_Y))
      |-> bank_o == $past(dbank_i));

  // R5: long operand passes through
  a_r5_long_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q && $past(mode_i) == 4'(AM_LONG))
      |-> {bank_o, ofs_o} == $past(long_i));

  // R9: code access uses the program bank and the operand offset
  a_r9_code_pbank: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q && $past(mode_i) == 4'(AM_CODE))
      |-> (bank_o == $past(pbank_i) && ofs_o == $past(abs_i)));

  // R11: no extra cycle outside direct-page modes or with an aligned base
  a_r11_no_penalty: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q && (!$past(dp_mode_w) || !$past(dp_misaligned_w))) |-> !extra_cyc_o);

  // R12: undefined codes produce a null address
  a_r12_undef_null: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q && $past(mode_i) > 4'(AM_CODE))
      |-> (bank_o == '0 && ofs_o == '0 && !extra_cyc_o));
endmodule

// File: tb/test_eag_top.sv
module test_eag_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode_i = 4'd6;
  logic        idx_narrow_i = 1'b0;
  logic [7:0]  dp_ofs_i = 8'h55;
  logic [15:0] abs_i = 16'h5555;
  logic [23:0] long_i = 24'h555555;
  logic [23:0] ptr_i = 24'h0;
  logic [15:0] x_i = 16'h0, y_i = 16'h0, sp_i = 16'h0, dpage_i = 16'h00FF;
  logic [7:0]  dbank_i = 8'h7E, pbank_i = 8'h05;
  logic [7:0]  bank_o;
  logic [15:0] ofs_o;
  logic        extra_cyc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  eag_top i_eag_top (
    .clk, .rst_n, .mode_i, .idx_narrow_i, .dp_ofs_i, .abs_i, .long_i, .ptr_i,
    .x_i, .y_i, .sp_i, .dpage_i, .dbank_i, .pbank_i,
    .bank_o, .ofs_o, .extra_cyc_o
  );

  typedef struct packed {
    logic [3:0]  mode;
    logic        narrow;
    logic [23:0] op;
    logic [23:0] ptr;
    logic [15:0] x, y, sp, d;
    logic        pen;
    logic [23:0] addr;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    {4'd0, 1'b0, 24'h000042, 24'h0, 16'h0, 16'h0, 16'h0, 16'h2000, 1'b0, 24'h002042},
    {4'd0, 1'b0, 24'h000020, 24'h0, 16'h0, 16'h0, 16'h0, 16'hFFF0, 1'b1, 24'h000010},
    {4'd1, 1'b0, 24'h000010, 24'h0, 16'h1234, 16'h0, 16'h0, 16'h0100, 1'b0, 24'h001344},
    {4'd1, 1'b1, 24'h000010, 24'h0, 16'h12F0, 16'h0, 16'h0, 16'h0100, 1'b0, 24'h000200},
    {4'd2, 1'b0, 24'h000080, 24'h0, 16'h0, 16'hFFFF, 16'h0, 16'h0001, 1'b1, 24'h000080},
    {4'd3, 1'b0, 24'h00ABCD, 24'h0, 16'h0, 16'h0, 16'h0, 16'h00FF, 1'b0, 24'h7EABCD},
    {4'd4, 1'b0, 24'h00FFF0, 24'h0, 16'h0020, 16'h0, 16'h0, 16'h0, 1'b0, 24'h7E0010},
    {4'd5, 1'b1, 24'h001000, 24'h0, 16'h0, 16'hAB05, 16'h0, 16'h0, 1'b0, 24'h7E1005},
    {4'd6, 1'b0, 24'h123456, 24'h0, 16'h0, 16'h0, 16'h0, 16'h0011, 1'b0, 24'h123456},
    {4'd7, 1'b0, 24'h12FFFF, 24'h0, 16'h0002, 16'h0, 16'h0, 16'h0, 1'b0, 24'h130001},
    {4'd7, 1'b1, 24'hFFFFFF, 24'h0, 16'h0101, 16'h0, 16'h0, 16'h0, 1'b0, 24'h000000},
    {4'd8, 1'b0, 24'h000003, 24'h0, 16'h0, 16'h0, 16'h01FC, 16'h0001, 1'b0, 24'h0001FF},
    {4'd8, 1'b0, 24'h0000FF, 24'h0, 16'h0, 16'h0, 16'hFFF0, 16'h0, 1'b0, 24'h0000EF},
    {4'd9, 1'b0, 24'h0, 24'h7F1234, 16'h0, 16'h0, 16'h0, 16'h0000, 1'b0, 24'h7F1234},
    {4'd10, 1'b0, 24'h0, 24'h7EFFFF, 16'h0, 16'h0003, 16'h0, 16'h0004, 1'b1, 24'h7F0002},
    {4'd11, 1'b0, 24'h008000, 24'h0, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 24'h058000},
    {4'd9, 1'b0, 24'h0, 24'h001234, 16'h0, 16'h0, 16'h0, 16'h0080, 1'b1, 24'h001234}
  };

  function automatic string tag_of(input vec_t v);
    if (v.narrow)                  return "R10";
    case (v.mode)
      4'd0: return "R2";
      4'd1, 4'd2: return "R3";
      4'd3, 4'd4, 4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      4'd9, 4'd10: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [24:0] act, input logic [24:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    mode_i       = v.mode;
    idx_narrow_i = v.narrow;
    dp_ofs_i     = v.op[7:0];
    abs_i        = v.op[15:0];
    long_i       = v.op;
    ptr_i        = v.ptr;
    x_i = v.x; y_i = v.y; sp_i = v.sp; dpage_i = v.d;
  endtask

  initial begin
    // R1: outputs held at zero during reset despite non-zero inputs
    repeat (2) @(negedge clk);
    check("R1", {extra_cyc_o, bank_o, ofs_o}, 25'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      #1;
      if (i > 0) check("R13", {1'b0, bank_o, ofs_o}, {1'b0, VECS[i-1].addr});
      @(negedge clk);
      check(tag_of(VECS[i]), {1'b0, bank_o, ofs_o}, {1'b0, VECS[i].addr});
      check("R11", {24'h0, extra_cyc_o}, {24'h0, VECS[i].pen});
    end

    // R12: undefined code with misaligned base gives null address, no penalty
    @(negedge clk);
    mode_i = 4'd14; dpage_i = 16'h1234; long_i = 24'hABCDEF; abs_i = 16'hBEEF;
    @(negedge clk);
    check("R12", {extra_cyc_o, bank_o, ofs_o}, 25'h0);

    // R10: full-width index when narrow select is clear (contrast to vector 4)
    mode_i = 4'd4; idx_narrow_i = 1'b0; abs_i = 16'h0010; x_i = 16'h0300;
    @(negedge clk);
    check("R10", {extra_cyc_o, bank_o, ofs_o}, {1'b0, 8'h7E, 16'h0310});
    idx_narrow_i = 1'b1;
    @(negedge clk);
    check("R10", {extra_cyc_o, bank_o, ofs_o}, {1'b0, 8'h7E, 16'h0010});

    // R9: program bank follows its input
    mode_i = 4'd11; pbank_i = 8'hC3; abs_i = 16'hFFFF;
    @(negedge clk);
    check("R9", {extra_cyc_o, bank_o, ofs_o}, {1'b0, 8'hC3, 16'hFFFF});

    // R1: reset asserted mid-run clears outputs at once
    rst_n = 1'b0;
    #1;
    check("R1", {extra_cyc_o, bank_o, ofs_o}, 25'h0);
    @(negedge clk);
    check("R1", {extra_cyc_o, bank_o, ofs_o}, 25'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", {extra_cyc_o, bank_o, ofs_o}, {1'b0, 8'hC3, 16'hFFFF});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule